// File: doc/BRIEF.md
# Byte-Strobed Synchronous Memory Data Path

This block is the write-strobe decoding and registered data path of a synchronous memory whose words are split into 9-bit bytes. Each byte carries eight data bits and one parity bit. Three write controls are combined by priority: a whole-word write command, a byte-write qualifier and one select line per byte. The result is a set of per-byte write strobes. Write data, strobes and address are captured in an input register stage and committed to the internal array on the next enabled clock edge. A read of a word whose write is still waiting to commit gets the new bytes through a forwarding path.

Read data is taken from the array into an output register. A word addressed at one rising edge is presented on `rdata` just after that edge and held until the next accepted read. The bidirectional data bus is modelled as separate `wdata`, `rdata` and `rdata_drive` ports. `rdata_drive` is high only when the asynchronous active-low `rd_oe_n` is low and the registered cycle type is a selected read. Write cycles and deselected cycles therefore silence the bus one cycle later. A high `nap` input freezes every register and the array, so the contents and any pending write are kept.

Top module: `bsmem_datapath`

## Requirements
- R1: With `cs` high and `wr_all_n` low at a rising edge, all NBYTES bytes of the addressed word are written, whatever `byte_qual_n` and `byte_sel_n` are.
- R2: With `cs` high, `wr_all_n` high and `byte_qual_n` low, exactly the bytes b whose `byte_sel_n[b]` is low are written. Byte b occupies data bits 9b to 9b+8, and the other bytes keep their contents.
- R3: With `wr_all_n` high and `byte_qual_n` high, no byte is written for any `byte_sel_n` value. A selected cycle of this kind is a read of `addr`.
- R4: With `cs` low, no write takes place and the output register is not updated.
- R5: A read accepted at a rising edge (`cs` high, no byte strobed) places the addressed word on `rdata` after that edge. `rdata` then holds its value through following non-read cycles.
- R6: A read of the word written at the previous accepted edge returns the newly written bytes, merged with the unwritten ones.
- R7: `rdata_drive` is low whenever `rd_oe_n` is high, independent of the clock. With `rd_oe_n` low it is high after an accepted read.
- R8: After an accepted cycle that strobes any byte, `rdata_drive` is low for the following cycle.
- R9: After an edge with `cs` low, `rdata_drive` is low. Deselection takes effect one cycle after the edge that samples it.
- R10: While `nap` is high, no register or array location changes. A write captured before `nap` rose commits at the first edge after `nap` falls, and commands presented during `nap` are ignored.
- R11: A synchronous active-high `rst` clears the output register to zero, clears any pending write and forces `rdata_drive` low. The array contents are not reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| nap | input | 1 | High freezes all internal state |
| cs | input | 1 | Chip selected for this cycle |
| addr | input | AW | Word address |
| wr_all_n | input | 1 | Active-low whole-word write |
| byte_qual_n | input | 1 | Active-low qualifier letting byte selects through |
| byte_sel_n | input | NBYTES | Active-low per-byte selects |
| wdata | input | NBYTES*BYTE_W | Write data |
| rd_oe_n | input | 1 | Asynchronous active-low output enable |
| rdata | output | NBYTES*BYTE_W | Registered read data |
| rdata_drive | output | 1 | High when the data bus should be driven |

## Verification
The bench sweeps every address and every byte-select pattern under each priority case. A decoder that let byte selects override the whole-word write, or leak through while the qualifier is high, shows up as wrong or missing bytes on read-back. Each byte-masked write is read back at once. A design without forwarding would return the stale word, and a wrong byte-to-bit mapping corrupts neighbouring lanes. Output-enable checks after writes, after deselects and across mid-cycle `rd_oe_n` changes expose a drive signal that is not pipelined or not asynchronous. A nap window with a conflicting write presented shows whether the pending write is lost, applied twice or overwritten.

// File: rtl/bsmem_pkg.sv
package bsmem_pkg;
  localparam int DEF_BYTE_W = 9;
  localparam int DEF_NBYTES = 4;
  localparam int DEF_DEPTH  = 16;

  typedef enum logic [1:0] {
    CYC_IDLE  = 2'd0,
    CYC_READ  = 2'd1,
    CYC_WRITE = 2'd2
  } cyc_kind_t;
endpackage

// File: rtl/bsmem_strobe_dec.sv
module bsmem_strobe_dec #(
  parameter int NBYTES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs,
  input  logic              wr_all_n,
  input  logic              byte_qual_n,
  input  logic [NBYTES-1:0] byte_sel_n,
  output logic [NBYTES-1:0] wr_stb
);
  logic whole_word;
  logic lanes_open;

  assign whole_word = cs && !wr_all_n;
  assign lanes_open = cs && !byte_qual_n;

  for (genvar b = 0; b < NBYTES; b++) begin : g_lane
    assign wr_stb[b] = whole_word || (lanes_open && !byte_sel_n[b]);
  end

  // R1: whole-word write wins over everything else
  p_all_bytes_r1: assert property (@(posedge clk) disable iff (rst)
    (cs && !wr_all_n) |-> (&wr_stb));
  // R3: qualifier high with no whole-word write blocks every select
  p_sel_blocked_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_all_n && byte_qual_n) |-> (wr_stb == '0));
  // R4: nothing strobes while deselected
  p_no_stb_desel_r4: assert property (@(posedge clk) disable iff (rst)
    !cs |-> (wr_stb == '0));
endmodule

// File: rtl/bsmem_in_stage.sv
module bsmem_in_stage
  import bsmem_pkg::*;
#(
  parameter int NBYTES = 4,
  parameter int BYTE_W = 9,
  parameter int AW     = 4,
  localparam int DW    = NBYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce,
  input  logic              cs,
  input  logic [NBYTES-1:0] wr_stb,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     wdata,
  output cyc_kind_t         kind_q,
  output logic [NBYTES-1:0] stb_q,
  output logic [AW-1:0]     addr_q,
  output logic [DW-1:0]     wdata_q
);
  cyc_kind_t kind_d;

  always_comb begin
    if (!cs)          kind_d = CYC_IDLE;
    else if (|wr_stb) kind_d = CYC_WRITE;
    else              kind_d = CYC_READ;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      kind_q <= CYC_IDLE;
      stb_q  <= '0;
    end else if (ce) begin
      kind_q <= kind_d;
      stb_q  <= wr_stb;
    end
  end

  always_ff @(posedge clk) begin
    if (ce) begin
      addr_q  <= addr;
      wdata_q <= wdata;
    end
  end

  // R10: a frozen cycle leaves the pending command untouched
  p_nap_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !ce |=> ($stable(stb_q) && $stable(kind_q) && $stable(addr_q)));
endmodule

// File: rtl/bsmem_array.sv
module bsmem_array #(
  parameter int NBYTES = 4,
  parameter int BYTE_W = 9,
  parameter int DEPTH  = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int DW    = NBYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce,
  input  logic              rd_req,
  input  logic [AW-1:0]     rd_addr,
  input  logic [NBYTES-1:0] wr_en_q,
  input  logic [AW-1:0]     wr_addr_q,
  input  logic [DW-1:0]     wr_data_q,
  output logic [DW-1:0]     rdata_q
);
  logic hit;
  assign hit = (wr_addr_q == rd_addr);

  for (genvar b = 0; b < NBYTES; b++) begin : g_lane
    logic [BYTE_W-1:0] mem [DEPTH];
    logic [BYTE_W-1:0] lane_wd;

    assign lane_wd = wr_data_q[b*BYTE_W +: BYTE_W];

    always_ff @(posedge clk) begin
      if (ce && wr_en_q[b]) mem[wr_addr_q] <= lane_wd;
    end

    always_ff @(posedge clk) begin
      if (rst)
        rdata_q[b*BYTE_W +: BYTE_W] <= '0;
      else if (ce && rd_req)
        rdata_q[b*BYTE_W +: BYTE_W] <= (wr_en_q[b] && hit) ? lane_wd : mem[rd_addr];
    end
  end

  // R5: output register only moves on an accepted read
  p_rdata_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !(ce && rd_req) |=> $stable(rdata_q));
endmodule

// File: rtl/bsmem_datapath.sv
module bsmem_datapath
  import bsmem_pkg::*;
#(
  parameter int NBYTES = DEF_NBYTES,
  parameter int BYTE_W = DEF_BYTE_W,
  parameter int DEPTH  = DEF_DEPTH,
  localparam int AW    = $clog2(DEPTH),
  localparam int DW    = NBYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              nap,
  input  logic              cs,
  input  logic [AW-1:0]     addr,
  input  logic              wr_all_n,
  input  logic              byte_qual_n,
  input  logic [NBYTES-1:0] byte_sel_n,
  input  logic [DW-1:0]     wdata,
  input  logic              rd_oe_n,
  output logic [DW-1:0]     rdata,
  output logic              rdata_drive
);
  logic              ce;
  logic              rd_req;
  logic [NBYTES-1:0] wr_stb;
  cyc_kind_t         kind_q;
  logic [NBYTES-1:0] stb_q;
  logic [AW-1:0]     addr_q;
  logic [DW-1:0]     wdata_q;

  assign ce     = !nap;
  assign rd_req = cs && (wr_stb == '0);

  bsmem_strobe_dec #(.NBYTES(NBYTES)) u_dec (
    .clk(clk), .rst(rst), .cs(cs), .wr_all_n(wr_all_n),
    .byte_qual_n(byte_qual_n), .byte_sel_n(byte_sel_n), .wr_stb(wr_stb)
  );

  bsmem_in_stage #(.NBYTES(NBYTES), .BYTE_W(BYTE_W), .AW(AW)) u_in (
    .clk(clk), .rst(rst), .ce(ce), .cs(cs), .wr_stb(wr_stb), .addr(addr),
    .wdata(wdata), .kind_q(kind_q), .stb_q(stb_q), .addr_q(addr_q),
    .wdata_q(wdata_q)
  );

  bsmem_array #(.NBYTES(NBYTES), .BYTE_W(BYTE_W), .DEPTH(DEPTH)) u_arr (
    .clk(clk), .rst(rst), .ce(ce), .rd_req(rd_req), .rd_addr(addr),
    .wr_en_q(stb_q), .wr_addr_q(addr_q), .wr_data_q(wdata_q), .rdata_q(rdata)
  );

  assign rdata_drive = !rd_oe_n && (kind_q == CYC_READ);

  // R7: output enable high always silences the bus
  p_oe_gate_r7: assert property (@(posedge clk) disable iff (rst)
    rd_oe_n |-> !rdata_drive);
  // R8: a strobed cycle mutes the bus on the following cycle
  p_wr_mute_r8: assert property (@(posedge clk) disable iff (rst)
    (ce && (wr_stb != '0)) |=> !rdata_drive);
  // R9: deselect reaches the bus one cycle later
  p_desel_mute_r9: assert property (@(posedge clk) disable iff (rst)
    (ce && !cs) |=> !rdata_drive);
  // R10: read data frozen during nap
  p_nap_rdata_r10: assert property (@(posedge clk) disable iff (rst)
    nap |=> $stable(rdata));
endmodule

// File: tb/bsmem_datapath_bench.sv
`timescale 1ns/1ps
module bsmem_datapath_bench;
  localparam int NB = 4, BW = 9, DEPTH = 16, AW = 4, DW = NB * BW;

  logic clk = 1'b0, rst = 1'b1, nap = 1'b0, cs = 1'b0;
  logic [AW-1:0] addr = '0;
  logic wr_all_n = 1'b1, byte_qual_n = 1'b1, rd_oe_n = 1'b0;
  logic [NB-1:0] byte_sel_n = '1;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic rdata_drive;

  int checks = 0, errors = 0;
  logic [DW-1:0] model [DEPTH];

  always #5 clk = ~clk;

  bsmem_datapath u_bsmem_datapath (
    .clk(clk), .rst(rst), .nap(nap), .cs(cs), .addr(addr),
    .wr_all_n(wr_all_n), .byte_qual_n(byte_qual_n), .byte_sel_n(byte_sel_n),
    .wdata(wdata), .rd_oe_n(rd_oe_n), .rdata(rdata), .rdata_drive(rdata_drive)
  );

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int a, input int k);
    logic [DW-1:0] p;
    p = 36'h9_3C5A_7E21 * DW'(a + 3) + DW'(k * 1031);
    return p;
  endfunction

  // drive at falling edge, let one rising edge pass, return at next falling edge
  task automatic op(input logic s, input logic g, input logic q,
                    input logic [NB-1:0] bs, input int a, input logic [DW-1:0] d);
    logic [NB-1:0] mask;
    cs = s; wr_all_n = g; byte_qual_n = q; byte_sel_n = bs;
    addr = AW'(a); wdata = d;
    mask = !s ? '0 : (!g ? '1 : (!q ? ~bs : '0));
    if (!nap)
      for (int b = 0; b < NB; b++)
        if (mask[b]) model[a][b*BW +: BW] = d[b*BW +: BW];
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd(input int a);
    op(1'b1, 1'b1, 1'b1, '1, a, '0);
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [DW-1:0] held;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R11 rdata after reset", rdata, '0);
    chk("R11 drive after reset", DW'(rdata_drive), '0);

    // R1: whole-word writes with every select/qualifier mix
    for (int a = 0; a < DEPTH; a++) begin
      op(1'b1, 1'b0, a[0], a[3:0], a, pat(a, 1));
      chk("R8 drive after write", DW'(rdata_drive), '0);
    end
    // R5: read back all
    for (int a = 0; a < DEPTH; a++) begin
      rd(a);
      chk("R1 R5 readback", rdata, model[a]);
      chk("R7 drive after read", DW'(rdata_drive), 1);
    end

    // R2 + R6: every byte mask, read immediately after
    for (int m = 0; m < 16; m++) begin
      op(1'b1, 1'b1, 1'b0, ~m[3:0], m, pat(m, 7));
      rd(m);
      chk("R2 R6 masked write forwarded", rdata, model[m]);
    end
    for (int m = 0; m < 16; m++) begin
      rd(m);
      chk("R2 masked write in array", rdata, model[m]);
    end

    // R3: qualifier high blocks selects; cycle acts as read
    for (int m = 0; m < 16; m++) begin
      op(1'b1, 1'b1, 1'b1, m[3:0], m, pat(m, 99));
      chk("R3 blocked selects", rdata, model[m]);
      rd(m);
      chk("R3 no write", rdata, model[m]);
    end

    // R4/R9: deselected write
    rd(5);
    held = rdata;
    op(1'b0, 1'b0, 1'b0, '0, 3, pat(3, 55));
    chk("R9 drive off after deselect", DW'(rdata_drive), '0);
    chk("R4 R5 rdata held while deselected", rdata, held);
    rd(3);
    chk("R4 deselected write ignored", rdata, model[3]);

    // R7: asynchronous output enable
    rd(6);
    rd_oe_n = 1'b1; #1;
    chk("R7 oe high mutes", DW'(rdata_drive), '0);
    rd_oe_n = 1'b0; #1;
    chk("R7 oe low drives", DW'(rdata_drive), 1);
    chk("R5 rdata unaffected by oe", rdata, model[6]);

    // R10: nap freezes pending write and ignores new commands
    op(1'b1, 1'b0, 1'b1, '1, 9, pat(9, 200));
    held = rdata;
    nap = 1'b1;
    for (int i = 0; i < 3; i++) begin
      op(1'b1, 1'b0, 1'b1, '1, 9, pat(9, 300 + i));
      chk("R10 rdata frozen", rdata, held);
      chk("R10 drive frozen", DW'(rdata_drive), '0);
    end
    for (int i = 0; i < 2; i++) begin
      rd(2);
      chk("R10 read ignored in nap", rdata, held);
    end
    nap = 1'b0;
    rd(9);
    chk("R10 pending write after wake", rdata, model[9]);
    rd(9);
    chk("R10 committed once", rdata, model[9]);

    // R11: reset mid-run clears output path
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    chk("R11 rdata cleared", rdata, '0);
    chk("R11 drive cleared", DW'(rdata_drive), '0);
    rd(9);
    chk("R11 array kept", rdata, model[9]);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule